// File: doc/BRIEF.md
# Response Reorder Buffer

This block sits on the response side of a network interface. Response packets come in from the network one per handshake. Each packet carries a transaction ID, a sequence number and a data word. The block hands them to the depacketizer so that, for every transaction ID, the sequence numbers come out in ascending order. A per-ID expected sequence number decides what happens to each packet. A packet that matches its expected number goes straight through to the output in the same cycle and is never stored. Any other packet is parked in one of a small set of table rows. Each row records the packet's ID, its sequence number and a pointer to the buffer slot that holds its data.

Every row compares its own sequence number with the current expected number for its ID, all in parallel. As a result, once an in-order delivery advances the expected number for an ID, the parked packet carrying the next number is found and offered on the output in the following cycle. That release is itself a delivery, so a run of consecutive parked packets drains at one per cycle. A pending release takes the output ahead of new input, and the input is held off while it waits.

Top module: `resp_reorder`

## Requirements
- R1: After reset, out_valid is low, the expected sequence number of every ID is 0 and no row is occupied, so in_ready is high while the input is idle.
- R2: A packet whose in_seq equals the expected number for its in_id appears on out_id/out_seq/out_data in the same cycle, with out_valid high, and in_ready then equals out_ready.
- R3: A packet whose in_seq differs from its expected number is accepted (in_ready high) while a free row exists, is stored, and does not appear on the output.
- R4: Each output handshake advances the expected number of out_id by one, modulo 16 (sequence field 4 bits wide), so 15 is followed by 0.
- R5: A stored packet whose ID matches a delivery and whose sequence number is the next one is offered on the output in the cycle after that delivery.
- R6: A run of consecutive stored packets of one ID drains at one packet per cycle, in sequence order, while out_ready is high.
- R7: While a stored packet is being offered, in_ready is low.
- R8: With all 8 rows occupied, an out-of-order packet sees in_ready low, while an in-order packet is still passed through.
- R9: A released row and its buffer slot become free again, so after a full table drains, 8 new out-of-order packets can be stored.
- R10: While out_ready is low, a packet being released stays on the output with stable out_id, out_seq and out_data.
- R11: A delivery on one ID never releases a stored packet of another ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming packet valid |
| in_ready | output | 1 | Block can take the incoming packet |
| in_id | input | 2 | Transaction ID of incoming packet |
| in_seq | input | 4 | Sequence number of incoming packet |
| in_data | input | 16 | Payload of incoming packet |
| out_valid | output | 1 | Ordered packet valid |
| out_ready | input | 1 | Depacketizer accepts the packet |
| out_id | output | 2 | Transaction ID of delivered packet |
| out_seq | output | 4 | Sequence number of delivered packet |
| out_data | output | 16 | Payload of delivered packet |

## Verification
A direct pass-through is due in the same cycle as its stimulus. The bench drives inputs just after a rising edge and reads out_valid and out_data at the next falling edge, before the handshake edge. A release is due one cycle after the delivery that enables it, and each further packet of a chain follows one cycle after the one before. The bench therefore checks chains at consecutive falling edges, counted from the return of the task that drove the enabling packet. The scoreboard monitor samples one time unit after each falling edge, so the driver has already queued the expected item when a same-cycle pass-through is compared.

// File: rtl/rr_pkg.sv
package rr_pkg;

  // Which source owns the output this cycle
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_DIRECT  = 2'd1,
    SRC_RELEASE = 2'd2
  } out_src_e;

  // Index of the lowest set bit, 0 when none is set (callers qualify with OR-reduce)
  function automatic int unsigned low_index(input logic [63:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/rr_seq_track.sv
module rr_seq_track #(
  parameter int ID_W    = 2,
  parameter int SEQ_W   = 4,
  parameter int NUM_IDS = 1 << ID_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ID_W-1:0]            lk_id,
  output logic [SEQ_W-1:0]           lk_exp,
  input  logic                       upd,
  input  logic [ID_W-1:0]            upd_id,
  output logic [NUM_IDS*SEQ_W-1:0]   exp_flat
);

  logic [SEQ_W-1:0] exp_q [NUM_IDS];
  logic [SEQ_W-1:0] upd_cur;

  // Sequence arithmetic: next number with natural wrap
  function automatic logic [SEQ_W-1:0] seq_next(input logic [SEQ_W-1:0] s);
    return s + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IDS; i++) exp_q[i] <= '0;
    end else if (upd) begin
      exp_q[upd_id] <= seq_next(exp_q[upd_id]);
    end
  end

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_flat
    assign exp_flat[g*SEQ_W +: SEQ_W] = exp_q[g];
  end

  assign lk_exp  = exp_q[lk_id];
  assign upd_cur = exp_q[upd_id];

  // R4
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> exp_q[$past(upd_id)] == SEQ_W'($past(upd_cur) + 1'b1));

endmodule

// File: rtl/rr_table.sv
module rr_table #(
  parameter int ROWS    = 8,
  parameter int ID_W    = 2,
  parameter int SEQ_W   = 4,
  parameter int DATA_W  = 16,
  parameter int NUM_IDS = 1 << ID_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IDS*SEQ_W-1:0]  exp_flat,
  input  logic                      store,
  input  logic [ID_W-1:0]           st_id,
  input  logic [SEQ_W-1:0]          st_seq,
  input  logic [DATA_W-1:0]         st_data,
  output logic                      has_free,
  input  logic                      rel_take,
  output logic                      rel_hit,
  output logic [ID_W-1:0]           rel_id,
  output logic [SEQ_W-1:0]          rel_seq,
  output logic [DATA_W-1:0]         rel_data
);

  localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  // Row fields: occupied flag, ID, sequence, pointer into the slot store
  logic [ROWS-1:0]   row_v_q;
  logic [ID_W-1:0]   row_id_q  [ROWS];
  logic [SEQ_W-1:0]  row_sn_q  [ROWS];
  logic [IDX_W-1:0]  row_ptr_q [ROWS];
  // Slot store with its free bitmap
  logic [ROWS-1:0]   slot_free_q;
  logic [DATA_W-1:0] slot_dat_q [ROWS];

  logic [ROWS-1:0]   hit_vec;
  logic [IDX_W-1:0]  rel_idx;
  logic [IDX_W-1:0]  rel_ptr;
  logic [IDX_W-1:0]  new_row;
  logic [IDX_W-1:0]  new_slot;

  // Every row compares itself with the expected number of its own ID
  for (genvar r = 0; r < ROWS; r++) begin : g_cmp
    assign hit_vec[r] = row_v_q[r] &&
                        (row_sn_q[r] == exp_flat[row_id_q[r]*SEQ_W +: SEQ_W]);
  end

  assign rel_hit  = |hit_vec;
  assign rel_idx  = IDX_W'(rr_pkg::low_index(64'(hit_vec)));
  assign rel_ptr  = row_ptr_q[rel_idx];
  assign rel_id   = row_id_q[rel_idx];
  assign rel_seq  = row_sn_q[rel_idx];
  assign rel_data = slot_dat_q[rel_ptr];

  assign has_free = ~&row_v_q;
  assign new_row  = IDX_W'(rr_pkg::low_index(64'(~row_v_q)));
  assign new_slot = IDX_W'(rr_pkg::low_index(64'(slot_free_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_v_q     <= '0;
      slot_free_q <= '1;
    end else begin
      if (rel_take && rel_hit) begin
        row_v_q[rel_idx]     <= 1'b0;
        slot_free_q[rel_ptr] <= 1'b1;
      end
      if (store) begin
        row_v_q[new_row]      <= 1'b1;
        slot_free_q[new_slot] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      row_id_q[new_row]    <= st_id;
      row_sn_q[new_row]    <= st_seq;
      row_ptr_q[new_row]   <= new_slot;
      slot_dat_q[new_slot] <= st_data;
    end
  end

  // R8
  store_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> has_free);

  // R9
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_take && rel_hit) |=> !row_v_q[$past(rel_idx)] && slot_free_q[$past(rel_ptr)]);

  // R9
  slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(row_v_q) + $countones(slot_free_q)) == ROWS);

endmodule

// File: rtl/resp_reorder.sv
module resp_reorder #(
  parameter int ID_W   = 2,
  parameter int SEQ_W  = 4,
  parameter int DATA_W = 16,
  parameter int ROWS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [DATA_W-1:0] out_data
);

  import rr_pkg::*;

  localparam int NUM_IDS = 1 << ID_W;

  logic [NUM_IDS*SEQ_W-1:0] exp_flat;
  logic [SEQ_W-1:0]         in_exp;
  logic [SEQ_W-1:0]         out_exp;
  logic                     in_order;
  logic                     has_free;
  logic                     rel_hit;
  logic [ID_W-1:0]          rel_id;
  logic [SEQ_W-1:0]         rel_seq;
  logic [DATA_W-1:0]        rel_data;
  out_src_e                 src;

  // Named events for the checks
  logic deliver_fire;
  logic store_fire;
  logic rel_fire;

  rr_seq_track #(.ID_W(ID_W), .SEQ_W(SEQ_W), .NUM_IDS(NUM_IDS)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_id    (in_id),
    .lk_exp   (in_exp),
    .upd      (deliver_fire),
    .upd_id   (out_id),
    .exp_flat (exp_flat)
  );

  rr_table #(.ROWS(ROWS), .ID_W(ID_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W),
             .NUM_IDS(NUM_IDS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .exp_flat (exp_flat),
    .store    (store_fire),
    .st_id    (in_id),
    .st_seq   (in_seq),
    .st_data  (in_data),
    .has_free (has_free),
    .rel_take (rel_fire),
    .rel_hit  (rel_hit),
    .rel_id   (rel_id),
    .rel_seq  (rel_seq),
    .rel_data (rel_data)
  );

  assign in_order = (in_seq == in_exp);

  always_comb begin
    if (rel_hit)                    src = SRC_RELEASE;
    else if (in_valid && in_order)  src = SRC_DIRECT;
    else                            src = SRC_NONE;
  end

  always_comb begin
    out_valid = (src != SRC_NONE);
    out_id    = in_id;
    out_seq   = in_seq;
    out_data  = in_data;
    if (src == SRC_RELEASE) begin
      out_id   = rel_id;
      out_seq  = rel_seq;
      out_data = rel_data;
    end
  end

  // A pending release owns the output; input waits
  assign in_ready     = !rel_hit && (in_order ? out_ready : has_free);
  assign deliver_fire = out_valid && out_ready;
  assign rel_fire     = rel_hit && out_ready;
  assign store_fire   = in_valid && in_ready && !in_order;
  assign out_exp      = exp_flat[out_id*SEQ_W +: SEQ_W];

  // R7
  rel_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit |-> !in_ready);

  // R10
  hold_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_hit && !out_ready) |=> rel_hit && $stable(out_id) && $stable(out_seq) && $stable(out_data));

  // R4
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_fire |-> out_seq == out_exp);

  // R3
  park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |-> !out_valid);

endmodule

// File: tb/sim_resp_reorder.sv
module sim_resp_reorder;

  localparam int ID_W = 2, SEQ_W = 4, DATA_W = 16, ROWS = 8, NID = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              in_valid, in_ready, out_valid, out_ready;
  logic [ID_W-1:0]   in_id, out_id;
  logic [SEQ_W-1:0]  in_seq, out_seq;
  logic [DATA_W-1:0] in_data, out_data;

  resp_reorder #(.ID_W(ID_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W), .ROWS(ROWS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_seq(in_seq), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_seq(out_seq), .out_data(out_data)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [SEQ_W-1:0]  sn;
    logic [DATA_W-1:0] d;
  } item_t;
  item_t sb_q[$];

  // Reference: expected number per ID and parked packets per (ID, seq)
  logic [SEQ_W-1:0]  m_exp [NID];
  bit                m_v   [NID][16];
  logic [DATA_W-1:0] m_d   [NID][16];

  function automatic void model_accept(input int id, input int sn, input int d);
    if (4'(sn) == m_exp[id]) begin
      sb_q.push_back(item_t'{id: ID_W'(id), sn: SEQ_W'(sn), d: DATA_W'(d)});
      m_exp[id] = m_exp[id] + 1'b1;
      while (m_v[id][m_exp[id]]) begin
        sb_q.push_back(item_t'{id: ID_W'(id), sn: m_exp[id], d: m_d[id][m_exp[id]]});
        m_v[id][m_exp[id]] = 1'b0;
        m_exp[id] = m_exp[id] + 1'b1;
      end
    end else begin
      m_v[id][sn] = 1'b1;
      m_d[id][sn] = DATA_W'(d);
    end
  endfunction

  // Values captured at the accepting falling edge
  logic              a_ov;
  logic [DATA_W-1:0] a_od;

  task automatic send(input int id, input int sn, input int d, input int max_wait, output bit acc);
    @(posedge clk); #1;
    in_valid = 1'b1; in_id = ID_W'(id); in_seq = SEQ_W'(sn); in_data = DATA_W'(d);
    acc = 1'b0;
    for (int w = 0; w < max_wait; w++) begin
      @(negedge clk);
      if (in_ready) begin
        acc  = 1'b1;
        a_ov = out_valid;
        a_od = out_data;
        model_accept(id, sn, d);
        break;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    item_t e;
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected output seq", int'(out_seq), -1);
      end else begin
        e = sb_q.pop_front();
        chk(out_id == e.id && out_seq == e.sn && out_data == e.d,
            "R6", "output order seq/data", int'({out_seq, out_data}), int'({e.sn, e.d}));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit acc;
    for (int i = 0; i < NID; i++) begin
      m_exp[i] = '0;
      for (int j = 0; j < 16; j++) begin m_v[i][j] = 1'b0; m_d[i][j] = '0; end
    end
    rst_n = 1'b0; in_valid = 1'b0; in_id = '0; in_seq = '0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R2 direct pass, same cycle
    send(0, 0, 16'hA000, 4, acc);
    chk(acc && a_ov && a_od == 16'hA000, "R2", "direct pass data", int'(a_od), 16'hA000);

    // R3 out-of-order parked
    send(0, 2, 16'hA002, 4, acc);
    chk(acc && !a_ov, "R3", "parked packet not on output", int'(a_ov), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R3", "parked packet stays hidden", int'(out_valid), 0);

    // R5 release one cycle after enabling delivery, R7 input held off
    send(0, 1, 16'hA001, 4, acc);
    chk(acc && a_ov, "R2", "in-order pass seq1", int'(a_ov), 1);
    @(negedge clk);
    chk(out_valid && out_seq == 4'd2, "R5", "release seq", int'(out_seq), 2);
    chk(in_ready == 1'b0, "R7", "in_ready during release", int'(in_ready), 0);

    // R6 chain of three on ID 2
    send(2, 3, 16'hC003, 4, acc);
    send(2, 2, 16'hC002, 4, acc);
    send(2, 1, 16'hC001, 4, acc);
    send(2, 0, 16'hC000, 4, acc);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_seq == SEQ_W'(k), "R6", "chain step seq", int'(out_seq), k);
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "chain ended", int'(out_valid), 0);

    // R10 hold while out_ready low
    send(1, 1, 16'hB001, 4, acc);
    send(1, 2, 16'hB002, 4, acc);
    send(1, 0, 16'hB000, 4, acc);
    out_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_seq == 4'd1 && out_data == 16'hB001, "R10", "held release data",
          int'(out_data), 16'hB001);
      chk(in_ready == 1'b0, "R7", "in_ready while release held", int'(in_ready), 0);
    end
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (3) @(negedge clk);

    // R4 wrap: ID 1 goes 3..15 then 0, 1
    for (int s = 3; s < 18; s++) begin
      send(1, s % 16, 16'hB100 + s, 4, acc);
      chk(acc && a_ov, (s == 16) ? "R4" : "R2", "in-order after advance", int'(a_ov), 1);
    end

    // R8 full table on ID 3
    for (int s = 1; s <= ROWS; s++) begin
      send(3, s, 16'hD000 + s, 4, acc);
      chk(acc && !a_ov, "R3", "park into free row", int'(acc), 1);
    end
    send(3, 9, 16'hD009, 4, acc);
    chk(!acc, "R8", "out-of-order refused when full", int'(acc), 0);
    send(0, int'(m_exp[0]), 16'hA0F0, 4, acc);
    chk(acc && a_ov, "R8", "in-order passes when full", int'(acc), 1);
    send(3, 0, 16'hD000, 4, acc);
    repeat (ROWS + 2) @(negedge clk);

    // R9 rows reused after drain; 15 -> 0 wrap inside the chain (R4)
    for (int s = 10; s < 18; s++) begin
      send(3, s % 16, 16'hD100 + s, 4, acc);
      chk(acc && !a_ov, "R9", "freed row accepts packet", int'(acc), 1);
    end
    send(3, 9, 16'hD109, 4, acc);
    repeat (ROWS + 2) @(negedge clk);
    chk(sb_q.size() == 0, "R9", "drained after reuse", sb_q.size(), 0);

    // R11 independence of IDs
    send(2, int'(m_exp[2]) + 1, 16'hC0E1, 4, acc);
    send(1, int'(m_exp[1]), 16'hB0E0, 4, acc);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "other ID stays parked", int'(out_valid), 0);
    send(2, int'(m_exp[2]), 16'hC0E0, 4, acc);
    @(negedge clk);
    chk(out_valid && out_data == 16'hC0E1, "R11", "own ID releases", int'(out_data), 16'hC0E1);

    repeat (20) @(negedge clk);
    chk(sb_q.size() == 0, "R6", "leftover expected items", sb_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule